// File: doc/BRIEF.md
# Multi-Channel Shadow-Updated PWM Generator

This block turns the running count of an external period timer into six pulse-width-modulated outputs. Seven compare values are held on chip. Compare 0 sets the period, and compares 1 to 6 place the pulse edges. Each output is either single-edge, or double-edge with both edges placed anywhere in the period. A double-edge output can therefore give a positive pulse or a negative pulse. All outputs repeat at the same rate.

Software writes new compare values into shadow copies and then marks them as released. A released value moves into the active set only when the timer reports the start of a period. A pulse in progress is therefore never cut by a half-updated pair of edges. The timer restarts its count when the block flags that the count has reached the compare-0 value in force.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset every output is low, every active and shadow compare is zero, and no compare is released.
- R2: A write to address m, for m from 0 to 6, stores the data in shadow compare m. The active compares change only in a cycle where `restart_i` is high.
- R3: Writing 1s to address 7 releases the compares whose bit numbers (bits 0 to 6) are set. In the next `restart_i` cycle those shadows become active and all release bits clear. A later shadow write without a new release has no effect.
- R4: A single-edge output n (n from 1 to 6, bit n-1 of `pwm_o`) goes high at period start. It goes low when the count equals compare n.
- R5: A single-edge output whose compare equals the count at period start (0) stays low for the whole period. One whose compare exceeds the period stays high.
- R6: A double-edge output n is set when the count equals compare n-1 and cleared when it equals compare n. A set compare above the clear compare gives a negative-going pulse that spans the period wrap.
- R7: If the set and clear conditions of an output hit in the same cycle, the clear wins and the output is low.
- R8: Output 1 is always single-edge. Its mode bit (bit 0 of address 9) has no effect.
- R9: Address 8 bit n-1 enables output n and address 9 bit n-1 selects double-edge mode for it; both take effect on the next cycle. A disabled output is low.
- R10: `period_hit_o` is high, combinationally, when `cnt_i` equals the compare-0 value in force in that cycle. In a `restart_i` cycle that value is the newly released one.
- R11: `pwm_o` is registered. It reflects the count presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Current count of the external period timer |
| restart_i | input | 1 | High in the cycle in which the timer count is 0 at period start |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register address |
| wr_data_i | input | CNT_W | Register write data |
| pwm_o | output | N_OUT | PWM outputs, bit n-1 is output n |
| period_hit_o | output | 1 | Count equals the period compare in force |

## Verification
The outputs are first run with only single-edge settings: one clear in mid-period, one compare at 0, and one compare beyond the period. This separates normal pulses from constant-low and constant-high outputs. Double-edge settings are then run with the set edge below the clear edge, above it, and equal to it. These tell a positive pulse from a wrapped negative pulse and from the clear-wins case. A mode bit is also set on output 1 to show that it is ignored. Shadow writes are made in mid-period both with and without a following release, which shows when the active values move. A final run with every output disabled confirms that no edge reaches a disabled pin.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

    typedef enum logic [2:0] {
        SEL_MATCH,
        SEL_RELEASE,
        SEL_ENABLE,
        SEL_MODE,
        SEL_NONE
    } reg_sel_e;

    // Address map: 0..n_out compares, then release, enable, mode.
    function automatic reg_sel_e pwm_decode(input logic [7:0] addr, input int n_out);
        if (int'(addr) <= n_out)          return SEL_MATCH;
        else if (int'(addr) == n_out + 1) return SEL_RELEASE;
        else if (int'(addr) == n_out + 2) return SEL_ENABLE;
        else if (int'(addr) == n_out + 3) return SEL_MODE;
        else                              return SEL_NONE;
    endfunction

endpackage

// File: rtl/pwm_match_bank.sv
module pwm_match_bank
    import pwm_shadow_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 7,
    parameter int AW      = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              restart_i,
    input  logic                              wr_en_i,
    input  logic [AW-1:0]                     wr_addr_i,
    input  logic [CNT_W-1:0]                  wr_data_i,
    output logic [N_MATCH-1:0][CNT_W-1:0]     eff_o,
    output logic [N_MATCH-1:0][CNT_W-1:0]     act_o,
    output logic [N_MATCH-1:0]                rel_o
);

    typedef struct packed {
        logic [N_MATCH-1:0][CNT_W-1:0] shadow;
        logic [N_MATCH-1:0][CNT_W-1:0] active;
        logic [N_MATCH-1:0]            release_m;
    } bank_t;

    bank_t    st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        sel  = pwm_decode(8'(wr_addr_i), N_MATCH - 1);
        st_d = st_q;
        for (int m = 0; m < N_MATCH; m++) begin
            // Value in force this cycle: a released shadow replaces the active copy at period start
            eff_o[m] = (restart_i && st_q.release_m[m]) ? st_q.shadow[m] : st_q.active[m];
            if (restart_i && st_q.release_m[m])
                st_d.active[m] = st_q.shadow[m];
        end
        if (restart_i)
            st_d.release_m = '0;
        if (wr_en_i && sel == SEL_RELEASE)
            st_d.release_m = st_d.release_m | wr_data_i[N_MATCH-1:0];
        for (int m = 0; m < N_MATCH; m++) begin
            if (wr_en_i && sel == SEL_MATCH && wr_addr_i == AW'(m))
                st_d.shadow[m] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.active;
    assign rel_o = st_q.release_m;

endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
    import pwm_shadow_pkg::*;
#(
    parameter int N_OUT = 6,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [N_OUT-1:0] wr_data_i,
    output logic [N_OUT-1:0] en_o,
    output logic [N_OUT-1:0] dbl_o
);

    typedef struct packed {
        logic [N_OUT-1:0] en;
        logic [N_OUT-1:0] dbl;
    } ctrl_t;

    ctrl_t    st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        sel  = pwm_decode(8'(wr_addr_i), N_OUT);
        st_d = st_q;
        if (wr_en_i && sel == SEL_ENABLE) st_d.en  = wr_data_i;
        if (wr_en_i && sel == SEL_MODE)   st_d.dbl = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign dbl_o = st_q.dbl;

endmodule

// File: rtl/pwm_edge_unit.sv
module pwm_edge_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             restart_i,
    input  logic             en_i,
    input  logic             dbl_i,
    input  logic [CNT_W-1:0] set_match_i,
    input  logic [CNT_W-1:0] clr_match_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic level;
    } edge_t;

    edge_t st_d, st_q;
    logic  set_hit, clr_hit;

    always_comb begin
        set_hit = dbl_i ? (cnt_i == set_match_i) : restart_i;
        clr_hit = (cnt_i == clr_match_i);
        st_d    = st_q;
        if (!en_i)        st_d.level = 1'b0;
        else if (clr_hit) st_d.level = 1'b0;   // clear beats set
        else if (set_hit) st_d.level = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.level;

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen #(
    parameter int CNT_W   = 16,
    parameter int N_OUT   = 6,
    localparam int N_MATCH = N_OUT + 1,
    localparam int AW      = $clog2(N_OUT + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             restart_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [N_OUT-1:0] pwm_o,
    output logic             period_hit_o
);

    logic [N_MATCH-1:0][CNT_W-1:0] eff_w;
    logic [N_MATCH-1:0][CNT_W-1:0] act_w;
    logic [N_MATCH-1:0]            rel_w;
    logic [N_OUT-1:0]              en_w;
    logic [N_OUT-1:0]              mode_w;

    pwm_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .eff_o     (eff_w),
        .act_o     (act_w),
        .rel_o     (rel_w)
    );

    pwm_ctrl_regs #(.N_OUT(N_OUT), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i[N_OUT-1:0]),
        .en_o      (en_w),
        .dbl_o     (mode_w)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        // Output 1 has no lower compare of its own and stays single-edge
        logic dbl_sel;
        if (g == 0) begin : g_first
            assign dbl_sel = 1'b0;
        end else begin : g_rest
            assign dbl_sel = mode_w[g];
        end

        pwm_edge_unit #(.CNT_W(CNT_W)) u_edge (
            .clk         (clk),
            .rst_n       (rst_n),
            .cnt_i       (cnt_i),
            .restart_i   (restart_i),
            .en_i        (en_w[g]),
            .dbl_i       (dbl_sel),
            .set_match_i (eff_w[g]),
            .clr_match_i (eff_w[g+1]),
            .pwm_o       (pwm_o[g])
        );
    end

    assign period_hit_o = (cnt_i == eff_w[0]);

endmodule

// File: rtl/pwm_shadow_gen_sva.sv
module pwm_shadow_gen_sva #(
    parameter int CNT_W   = 16,
    parameter int N_OUT   = 6,
    localparam int N_MATCH = N_OUT + 1,
    localparam int AW      = $clog2(N_OUT + 4)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [CNT_W-1:0]              cnt_i,
    input logic                          restart_i,
    input logic                          wr_en_i,
    input logic [AW-1:0]                 wr_addr_i,
    input logic [N_OUT-1:0]              pwm_o,
    input logic [N_OUT-1:0]              en,
    input logic [N_OUT-1:0]              mode,
    input logic [N_MATCH-1:0][CNT_W-1:0] act,
    input logic [N_MATCH-1:0]            rel
);

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> $stable(act)); // R2

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !(wr_en_i && wr_addr_i == AW'(N_OUT + 1))) |=> (rel == '0)); // R3

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en != '1) |=> ((pwm_o & ~$past(en)) == '0)); // R9

    for (genvar k = 1; k <= N_OUT; k++) begin : g_chk
        AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart_i && cnt_i == act[k]) |=> !pwm_o[k-1]); // R7

        if (k == 1) begin : g_single
            AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                (restart_i && en[0] && !rel[1] && cnt_i != act[1]) |=> pwm_o[0]); // R8
        end else begin : g_any
            AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                (restart_i && en[k-1] && !mode[k-1] && !rel[k] && cnt_i != act[k]) |=> pwm_o[k-1]); // R4
        end
    end

endmodule

bind pwm_shadow_gen pwm_shadow_gen_sva #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_i),
    .restart_i (restart_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .pwm_o     (pwm_o),
    .en        (en_w),
    .mode      (mode_w),
    .act       (act_w),
    .rel       (rel_w)
);

// File: tb/tb_pwm_shadow_gen.sv
module tb_pwm_shadow_gen;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int N_OUT = 6;
    localparam int N_M   = N_OUT + 1;
    localparam int AW    = $clog2(N_OUT + 4);
    localparam logic [AW-1:0] A_REL  = AW'(N_OUT + 1);
    localparam logic [AW-1:0] A_EN   = AW'(N_OUT + 2);
    localparam logic [AW-1:0] A_MODE = AW'(N_OUT + 3);
    localparam logic [CNT_W-1:0] IDLE = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_i = IDLE;
    logic             restart_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [AW-1:0]    wr_addr_i = '0;
    logic [CNT_W-1:0] wr_data_i = '0;
    logic [N_OUT-1:0] pwm_o;
    logic             period_hit_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_shadow_gen #(.CNT_W(CNT_W), .N_OUT(N_OUT)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .restart_i(restart_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .pwm_o(pwm_o), .period_hit_o(period_hit_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string tag = "R1";

    typedef struct { logic [N_OUT-1:0] exp; string req; } item_t;
    item_t sb_q[$];

    // Reference model state, kept from the requirements
    logic [CNT_W-1:0] m_act [N_M];
    logic [CNT_W-1:0] m_sh  [N_M];
    logic [N_M-1:0]   m_rel;
    logic [N_OUT-1:0] m_en, m_mode, m_out;

    function automatic void model_reset();
        for (int m = 0; m < N_M; m++) begin m_act[m] = '0; m_sh[m] = '0; end
        m_rel = '0; m_en = '0; m_mode = '0; m_out = '0;
    endfunction

    task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one clock of stimulus, pushes the expected registered output (R11)
    task automatic step(input logic [CNT_W-1:0] c, input logic rs,
                        input logic we, input logic [AW-1:0] a, input logic [CNT_W-1:0] d);
        logic [CNT_W-1:0] eff [N_M];
        logic [N_OUT-1:0] nx;
        item_t it;
        @(negedge clk);
        cnt_i = c; restart_i = rs; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
        for (int m = 0; m < N_M; m++) eff[m] = (rs && m_rel[m]) ? m_sh[m] : m_act[m];
        #1;
        check("R10", {5'b0, period_hit_o}, {5'b0, c == eff[0]});
        for (int o = 0; o < N_OUT; o++) begin
            logic setm, clrm;
            clrm = (c == eff[o+1]);
            setm = (m_mode[o] && o > 0) ? (c == eff[o]) : rs;   // R8 output 1 single
            nx[o] = !m_en[o] ? 1'b0 : clrm ? 1'b0 : setm ? 1'b1 : m_out[o];
        end
        m_out = nx;
        if (rs) begin
            for (int m = 0; m < N_M; m++) if (m_rel[m]) m_act[m] = m_sh[m];
            m_rel = '0;
        end
        if (we) begin
            if (int'(a) < N_M) m_sh[a] = d;
            else if (a == A_REL)  m_rel = m_rel | d[N_M-1:0];
            else if (a == A_EN)   m_en = d[N_OUT-1:0];
            else if (a == A_MODE) m_mode = d[N_OUT-1:0];
        end
        it.exp = nx; it.req = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [CNT_W-1:0] d);
        step(IDLE, 1'b0, 1'b1, a, d);
    endtask

    // One full period; optional write at count 'at'
    task automatic period(input bit do_wr, input int at,
                          input logic [AW-1:0] a, input logic [CNT_W-1:0] d);
        int per;
        step('0, 1'b1, do_wr && at == 0, a, d);
        per = int'(m_act[0]);
        for (int c = 1; c <= per; c++)
            step(CNT_W'(c), 1'b0, do_wr && at == c, a, d);
    endtask

    // Monitor: pops one expected item per clock
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, pwm_o, it.exp);
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1", pwm_o, '0);                 // R1 outputs low after reset
        @(negedge clk); rst_n = 1'b1;
        tag = "R1"; step(IDLE, 1'b0, 1'b0, '0, '0);

        // Single-edge setup, written to shadows only
        tag = "R2";
        wr(0, 9); wr(1, 4); wr(2, 0); wr(3, 20); wr(4, 3); wr(5, 7); wr(6, 7);
        wr(A_EN, 16'h0037);                     // output 4 disabled
        period(0, 0, '0, '0);                   // R2 actives still zero
        period(0, 0, '0, '0);

        tag = "R3,R4,R5,R9";
        wr(A_REL, 16'h007F);
        period(0, 0, '0, '0);
        period(0, 0, '0, '0);

        // Shadow change without release: no effect (R2, R3)
        tag = "R2,R3";
        period(1, 3, 1, 6);
        period(0, 0, '0, '0);

        // Double-edge setup: positive, wrapped negative, coincident
        tag = "R6,R7,R8";
        wr(2, 2); wr(3, 6); wr(4, 7); wr(5, 2); wr(6, 2);
        wr(A_MODE, 16'h0035);                   // bit0 set but ignored
        wr(A_REL, 16'h007F);
        period(0, 0, '0, '0);
        period(0, 0, '0, '0);
        period(0, 0, '0, '0);

        // New period length released mid-period
        tag = "R3,R10";
        period(1, 5, 0, 12);
        period(1, 2, A_REL, 16'h0001);
        period(0, 0, '0, '0);

        tag = "R9";
        wr(A_EN, 16'h0000);
        period(0, 0, '0, '0);

        repeat (3) @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule